// File: doc/BRIEF.md
# Digital I/O Register Block with Change-of-State Interrupt

This block holds the byte-wide registers of a digital I/O card with sixteen output lines and sixteen input lines, reached over a simple host bus with a 3-bit address. The outputs are held in two 8-bit latches that the host writes and reads back. The inputs are synchronized, can be filtered, and can be read as two bytes. Any accepted change of level on any input, rising or falling, latches a pending interrupt.

Several addresses act on the type of access rather than on the data. A read of the interrupt-control address turns interrupts on and a write turns them off. A read of the filter-control address turns filtering on for all inputs and a write turns it off. A write to the low-input address clears the pending interrupt. When filtering is on, an input must hold its new level for a fixed number of cycles before it counts as a change. The host claims an interrupt as its own when status bit 2 is set together with bit 0 or bit 1.

Top module: `iocos_regs`

## Requirements
- R1: After reset, both output latches are 0x00, interrupts are disabled, nothing is pending, filtering is off, and a read of address 6 returns 0x00.
- R2: A write to address 0 sets output lines 7..0 and a write to address 4 sets output lines 15..8. A read of either address returns the value last written there. No other access changes the latches.
- R3: Any write to address 1, whatever its data, clears the pending flag and status bits 0 and 1. A change that is accepted in the same cycle as the clear still sets them.
- R4: Any read of address 2 enables interrupts. Any write to address 2 disables them, whatever its data.
- R5: Any read of address 3 turns input filtering on. Any write to address 3 turns it off.
- R6: A change of an accepted input level in either direction sets the pending flag.
- R7: A read of address 6 returns the status byte. Bit 0 is set by a change on inputs 7..0, bit 1 by a change on inputs 15..8, and bit 2 is the pending flag. Bits 7..3 read 0.
- R8: The irq output is high exactly when the pending flag is set and interrupts are enabled.
- R9: A read of address 1 returns the accepted levels of inputs 7..0 and a read of address 5 returns inputs 15..8. Each input passes through two synchronizer flops before it is accepted.
- R10: Writes to addresses 5 and 6 change no output latch, no status bit and no input reading.
- R11: With filtering on, a new input level held for 3 cycles is rejected. A level held for 4 cycles is accepted.
- R12: With filtering off, an input pulse lasting a single cycle is accepted as a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| in_lo | input | 8 | Input lines 7..0 |
| in_hi | input | 8 | Input lines 15..8 |
| out_lo | output | 8 | Output lines 7..0 |
| out_hi | output | 8 | Output lines 15..8 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a filter hold of four cycles. With these values the filter boundary sits a single cycle apart, so a three-cycle glitch must be dropped and a four-cycle hold must be taken. The bench also samples the input byte at a point inside the hold, where the new level must not show yet. Access-triggered side effects are tested with data patterns that would mislead a design that decodes the data, and edges are applied in both directions on both byte groups.

// File: rtl/iocos_pkg.sv
package iocos_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_OUT_LO  = 3'd0,
        A_IN_LO   = 3'd1,
        A_IRQ_CTL = 3'd2,
        A_FLT_CTL = 3'd3,
        A_OUT_HI  = 3'd4,
        A_IN_HI   = 3'd5,
        A_STATUS  = 3'd6,
        A_SPARE   = 3'd7
    } reg_addr_e;

    localparam int ST_LO   = 0;
    localparam int ST_HI   = 1;
    localparam int ST_PEND = 2;

    typedef struct packed {
        logic out_lo_wr;
        logic out_hi_wr;
        logic irq_clr;
        logic irq_on;
        logic irq_off;
        logic flt_on;
        logic flt_off;
    } strobe_t;

    function automatic strobe_t decode_access(logic sel, logic wr, logic [ADDR_W-1:0] addr);
        strobe_t s;
        s = '0;
        if (sel) begin
            unique case (reg_addr_e'(addr))
                A_OUT_LO:  s.out_lo_wr = wr;
                A_IN_LO:   s.irq_clr   = wr;
                A_IRQ_CTL: begin s.irq_on = !wr; s.irq_off = wr; end
                A_FLT_CTL: begin s.flt_on = !wr; s.flt_off = wr; end
                A_OUT_HI:  s.out_hi_wr = wr;
                default:   s = '0;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/iocos_in_cond.sv
module iocos_in_cond #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flt_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [SYNC_STAGES-1:0] sr;
        logic [CNT_W-1:0]       cnt;
        logic                   lvl;
        logic                   s;

        always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[SYNC_STAGES-2:0], din[b]};
        end

        assign s = sr[SYNC_STAGES-1];

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl <= 1'b0;
                cnt <= '0;
            end else if (!flt_en) begin
                lvl <= s;
                cnt <= '0;
            end else if (s == lvl) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                lvl <= s;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end

        assign dout[b] = lvl;
    end
endmodule

// File: rtl/iocos_chg_det.sv
module iocos_chg_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign chg = lvl ^ prev;
endmodule

// File: rtl/iocos_irq_core.sv
module iocos_irq_core
    import iocos_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [2*PORT_W-1:0] chg,
    output logic              pending,
    output logic              irq_en,
    output logic [DATA_W-1:0] status
);
    logic chg_lo, chg_hi, st_lo, st_hi;

    assign chg_lo = |chg[PORT_W-1:0];
    assign chg_hi = |chg[2*PORT_W-1:PORT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_lo   <= 1'b0;
            st_hi   <= 1'b0;
            pending <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            st_lo   <= chg_lo | (st_lo & !stb.irq_clr);
            st_hi   <= chg_hi | (st_hi & !stb.irq_clr);
            pending <= chg_lo | chg_hi | (pending & !stb.irq_clr);
            if (stb.irq_on)       irq_en <= 1'b1;
            else if (stb.irq_off) irq_en <= 1'b0;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_LO]   = st_lo;
        status[ST_HI]   = st_hi;
        status[ST_PEND] = pending;
    end
endmodule

// File: rtl/iocos_regs.sv
module iocos_regs
    import iocos_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] in_hi,
    output logic [DATA_W-1:0] out_lo,
    output logic [DATA_W-1:0] out_hi,
    output logic              irq
);
    localparam int PORT_W = DATA_W;
    localparam int IN_W   = 2 * PORT_W;

    strobe_t           stb;
    logic              flt_en;
    logic [IN_W-1:0]   lvl;
    logic [IN_W-1:0]   chg;
    logic              chg_any;
    logic              pending;
    logic              irq_en;
    logic [DATA_W-1:0] status;

    assign stb = decode_access(bus_sel, bus_wr, bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_lo <= '0;
            out_hi <= '0;
            flt_en <= 1'b0;
        end else begin
            if (stb.out_lo_wr) out_lo <= bus_wdata;
            if (stb.out_hi_wr) out_hi <= bus_wdata;
            if (stb.flt_on)       flt_en <= 1'b1;
            else if (stb.flt_off) flt_en <= 1'b0;
        end
    end

    iocos_in_cond #(
        .W(IN_W), .SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)
    ) u_in_cond (
        .clk(clk), .rst(rst), .flt_en(flt_en),
        .din({in_hi, in_lo}), .dout(lvl)
    );

    iocos_chg_det #(.W(IN_W)) u_chg_det (
        .clk(clk), .rst(rst), .lvl(lvl), .chg(chg)
    );

    assign chg_any = |chg;

    iocos_irq_core #(.PORT_W(PORT_W)) u_irq_core (
        .clk(clk), .rst(rst), .stb(stb), .chg(chg),
        .pending(pending), .irq_en(irq_en), .status(status)
    );

    assign irq = pending & irq_en;

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_OUT_LO: bus_rdata = out_lo;
            A_IN_LO:  bus_rdata = lvl[PORT_W-1:0];
            A_OUT_HI: bus_rdata = out_hi;
            A_IN_HI:  bus_rdata = lvl[IN_W-1:PORT_W];
            A_STATUS: bus_rdata = status;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/iocos_regs_chk.sv
module iocos_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] out_lo,
    input logic       irq_en,
    input logic       flt_en,
    input logic       pending,
    input logic       chg_any
);
    AST_IRQ_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 3'd2) |=> irq_en); // R4
    AST_IRQ_OFF_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd2) |=> !irq_en); // R4
    AST_FILT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 3'd3) |=> flt_en); // R5
    AST_FILT_OFF_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd3) |=> !flt_en); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd1 && !chg_any) |=> !pending); // R3
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(chg_any)); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr == 3'd0) |=> $stable(out_lo)); // R2
endmodule

bind iocos_regs iocos_regs_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .out_lo(out_lo), .irq_en(irq_en),
    .flt_en(flt_en), .pending(pending), .chg_any(chg_any)
);

// File: tb/iocos_regs_tb.sv
module iocos_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] in_lo = '0;
    logic [7:0] in_hi = '0;
    logic [7:0] out_lo, out_hi;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iocos_regs u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_lo(in_lo), .in_hi(in_hi), .out_lo(out_lo), .out_hi(out_hi),
        .irq(irq)
    );

    // {wr, check, addr[2:0], wdata[7:0], expected[7:0]}; inputs held at A5 / 3C
    localparam logic [20:0] VT [0:NVEC-1] = '{
        {1'b1, 1'b0, 3'd0, 8'h5A, 8'h00},   // R2 write low latch
        {1'b0, 1'b1, 3'd0, 8'h00, 8'h5A},   // R2
        {1'b1, 1'b0, 3'd4, 8'hC3, 8'h00},   // R2 write high latch
        {1'b0, 1'b1, 3'd4, 8'h00, 8'hC3},   // R2
        {1'b0, 1'b1, 3'd0, 8'h00, 8'h5A},   // R2 untouched by other write
        {1'b1, 1'b0, 3'd1, 8'hFF, 8'h00},   // R3 clear with non-zero data
        {1'b0, 1'b1, 3'd6, 8'h00, 8'h00},   // R3 status cleared
        {1'b0, 1'b1, 3'd1, 8'h00, 8'hA5},   // R9 low inputs
        {1'b0, 1'b1, 3'd5, 8'h00, 8'h3C},   // R9 high inputs
        {1'b1, 1'b0, 3'd5, 8'hFF, 8'h00},   // R10
        {1'b1, 1'b0, 3'd6, 8'hFF, 8'h00},   // R10
        {1'b0, 1'b1, 3'd6, 8'h00, 8'h00},   // R10 status unchanged
        {1'b0, 1'b1, 3'd5, 8'h00, 8'h3C},   // R10 input reading unchanged
        {1'b0, 1'b1, 3'd0, 8'h00, 8'h5A},   // R10 latches unchanged
        {1'b0, 1'b1, 3'd4, 8'h00, 8'hC3},   // R10
        {1'b0, 1'b1, 3'd7, 8'h00, 8'h00}    // R9 spare address reads zero
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_acc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                           output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #(CLK_PERIOD/4);
        rd = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_acc(1'b0, a, 8'h00, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] v;
        bus_acc(1'b1, a, d, v);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 out_lo", out_lo, 8'h00);
        check("R1 out_hi", out_hi, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd_chk("R1 status", 3'd6, 8'h00);

        // both groups change while interrupts are disabled
        in_lo = 8'hA5; in_hi = 8'h3C;
        wait_cyc(8);
        rd_chk("R7 both groups", 3'd6, 8'h07);
        check("R8 disabled irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] v;
            bus_acc(VT[i][20], VT[i][18:16], VT[i][15:8], v);
            if (VT[i][19]) check($sformatf("R2/R3/R9/R10 vector %0d", i), v, VT[i][7:0]);
        end

        // falling edge on high group
        in_hi = 8'h34;
        wait_cyc(8);
        rd_chk("R6 R7 falling high", 3'd6, 8'h06);
        check("R8 pending but disabled", {7'b0, irq}, 8'h00);
        rd_chk("R9 high after fall", 3'd5, 8'h34);
        wait_cyc(1);
        // the status read above is not the enable address; enable now
        rd_chk("R9 ctl reads zero", 3'd2, 8'h00);
        check("R4 R8 read enables", {7'b0, irq}, 8'h01);
        wr(3'd2, 8'hFF);
        check("R4 write disables", {7'b0, irq}, 8'h00);
        rd_chk("R4 pending kept", 3'd6, 8'h06);
        rd_chk("R4 re-enable", 3'd2, 8'h00);
        check("R8 irq again", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'h00);
        check("R3 irq cleared", {7'b0, irq}, 8'h00);
        rd_chk("R3 status cleared", 3'd6, 8'h00);

        // filtering on: 3-cycle glitch is dropped
        rd_chk("R5 filter on", 3'd3, 8'h00);
        in_lo = 8'hA4;
        wait_cyc(3);
        in_lo = 8'hA5;
        wait_cyc(12);
        rd_chk("R11 glitch rejected", 3'd6, 8'h00);
        check("R11 no irq", {7'b0, irq}, 8'h00);
        // held level is taken after 4 cycles, not before
        in_lo = 8'hA4;
        wait_cyc(2);
        rd_chk("R11 not yet accepted", 3'd1, 8'hA5);
        wait_cyc(12);
        rd_chk("R11 accepted", 3'd1, 8'hA4);
        rd_chk("R11 status low", 3'd6, 8'h05);
        check("R11 irq", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'h5A);

        // filtering off: a single-cycle pulse counts
        wr(3'd3, 8'hFF);
        in_hi = 8'h35;
        wait_cyc(1);
        in_hi = 8'h34;
        wait_cyc(8);
        rd_chk("R12 pulse seen", 3'd6, 8'h06);
        rd_chk("R12 level restored", 3'd5, 8'h34);
        check("R12 irq", {7'b0, irq}, 8'h01);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule